// File: doc/BRIEF.md
# Multi-channel time-over-threshold hit digitizer

This block turns the binary outputs of a set of discriminators into digital hit records. Each channel samples its discriminator bit on the sample clock, nominally 15 MHz, so one count is about 67 ns. When a pulse starts, the channel latches a coarse time stamp from a free-running time base. It counts the samples for which the pulse stays high. When the pulse ends, it compresses that count into a 4-bit logarithmic code.

Finished hits go into a small per-channel first-in first-out store. A reader drains the store one record at a time with a pop request, or empties it at once with a clear request. Capture, coding and readout all run at the same time, so a channel can record a new pulse while a reader drains older hits. All channels are identical parallel instances that share the clock and the time base.

Top module: `tot_digitizer`

## Requirements
- R1: After reset, every channel shows no valid record and no overflow.
- R2: A pulse that is sampled high on N consecutive rising clock edges (N from 1 to 32767) yields the code floor(log2(N)) on `hit_tot`. N=1 gives 0, N=2..3 give 1, N=100 gives 6.
- R3: A pulse of 32768 or more high samples yields code 15, including pulses long enough to saturate the duration counter.
- R4: `hit_ts` holds the value of `tbase` at the second rising edge after the first high sample, which is the edge where the synchronised input first reads high.
- R5: Each channel stores up to 4 hits and presents them oldest first. The head record stays stable until a pop or a clear.
- R6: A hit that finishes while 4 records are stored is discarded, and the channel's `hit_ovf` rises. `hit_ovf` stays high until a clear.
- R7: A clear empties the channel's store and drops `hit_ovf` on the next cycle. A hit finishing in the same cycle as the clear is discarded.
- R8: A pulse that is still high produces no record, even across pops of the store. Its record appears only after its falling edge.
- R9: Channels are independent. Popping one channel does not disturb a pulse being measured on another.
- R10: A pop on an empty channel has no effect on later stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| disc | input | NCH | Discriminator bit per channel, asynchronous |
| tbase | input | TSW | Free-running coarse time base |
| rd_pop | input | NCH | Remove the head record of a channel |
| rd_clr | input | NCH | Empty a channel's store and clear its overflow |
| hit_valid | output | NCH | Channel has at least one record |
| hit_tot | output | 4*NCH | Logarithmic duration code of each head record |
| hit_ts | output | TSW*NCH | Leading-edge time stamp of each head record |
| hit_ovf | output | NCH | Sticky overflow per channel |

## Verification
The assertions assume that `rd_pop` and `rd_clr` are synchronous to `clk`, and that the reader issues pops only to channels whose `hit_valid` is high or tolerates the no-op. They rely on the store reporting only through its head outputs. The stimulus drives every input on the falling clock edge. It holds `tbase` still for the whole length of each pulse, so the expected time stamp does not depend on which edge the synchroniser uses. The bench spaces pulses at least several cycles apart, so each falling edge is seen before the next rising edge.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int TOT_W   = 4;
  localparam int TOT_MAX = 15;

  // floor(log2(n)) clamped to the code range, 0 for n of 0 or 1
  function automatic logic [TOT_W-1:0] tot_code(input logic [31:0] n);
    int m;
    m = 0;
    for (int b = 0; b < 32; b++) begin
      if (n[b]) m = b;
    end
    if (m > TOT_MAX) return TOT_W'(TOT_MAX);
    return m[TOT_W-1:0];
  endfunction
endpackage

// File: rtl/tot_sync.sv
module tot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tot_measure.sv
module tot_measure
  import tot_pkg::*;
#(
  parameter int CW  = 16,
  parameter int TSW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp,
  input  logic [TSW-1:0]   tbase,
  output logic             done,
  output logic [TOT_W-1:0] code,
  output logic [TSW-1:0]   ts
);
  logic          busy;
  logic [CW-1:0] cnt;
  logic [31:0]   cnt_ext;

  assign cnt_ext = 32'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
      code <= '0;
      ts   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (smp) begin
          busy <= 1'b1;
          cnt  <= CW'(1);
          ts   <= tbase;
        end
      end else if (smp) begin
        if (cnt != '1) cnt <= cnt + CW'(1);
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        code <= tot_code(cnt_ext);
      end
    end
  end
endmodule

// File: rtl/tot_store.sv
module tot_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          clr,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          ovf
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CNTW-1:0] fill;
  logic            full, pop_ok, push_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (fill == CNTW'(DEPTH));
  assign pop_ok  = pop && (fill != '0) && !clr;
  assign push_ok = push && !clr && (!full || pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
      ovf  <= 1'b0;
    end else begin
      if (push_ok) wp <= adv(wp);
      if (pop_ok)  rp <= adv(rp);
      fill <= fill + CNTW'(push_ok) - CNTW'(pop_ok);
      if (push && !push_ok) ovf <= 1'b1;
    end
  end

  assign valid = (fill != '0);
  assign dout  = mem[rp];
endmodule

// File: rtl/tot_digitizer.sv
module tot_digitizer
  import tot_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int TSW   = 5,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH-1:0]     disc,
  input  logic [TSW-1:0]     tbase,
  input  logic [NCH-1:0]     rd_pop,
  input  logic [NCH-1:0]     rd_clr,
  output logic [NCH-1:0]     hit_valid,
  output logic [NCH*4-1:0]   hit_tot,
  output logic [NCH*TSW-1:0] hit_ts,
  output logic [NCH-1:0]     hit_ovf
);
  localparam int RW = TOT_W + TSW;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             smp, done;
    logic [TOT_W-1:0] code;
    logic [TSW-1:0]   ts;
    logic [RW-1:0]    rec;

    tot_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst(rst), .din(disc[i]), .dout(smp)
    );

    tot_measure #(.CW(CW), .TSW(TSW)) u_meas (
      .clk(clk), .rst(rst), .smp(smp), .tbase(tbase),
      .done(done), .code(code), .ts(ts)
    );

    tot_store #(.DEPTH(DEPTH), .DW(RW)) u_store (
      .clk(clk), .rst(rst), .push(done), .din({code, ts}),
      .pop(rd_pop[i]), .clr(rd_clr[i]),
      .valid(hit_valid[i]), .dout(rec), .ovf(hit_ovf[i])
    );

    assign hit_tot[i*4 +: 4]    = rec[RW-1 -: TOT_W];
    assign hit_ts[i*TSW +: TSW] = rec[TSW-1:0];
  end
endmodule

// File: rtl/tot_digitizer_chk.sv
module tot_digitizer_chk #(
  parameter int NCH = 4,
  parameter int TSW = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NCH-1:0]     rd_pop,
  input logic [NCH-1:0]     rd_clr,
  input logic [NCH-1:0]     hit_valid,
  input logic [NCH*4-1:0]   hit_tot,
  input logic [NCH*TSW-1:0] hit_ts,
  input logic [NCH-1:0]     hit_ovf
);
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (hit_valid == '0 && hit_ovf == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r5_head_stable: assert property (@(posedge clk) disable iff (rst)
      (hit_valid[i] && !rd_pop[i] && !rd_clr[i]) |=>
        (hit_valid[i] && $stable(hit_tot[i*4 +: 4]) && $stable(hit_ts[i*TSW +: TSW])));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      (hit_ovf[i] && !rd_clr[i]) |=> hit_ovf[i]);

    a_r6_ovf_needs_full: assert property (@(posedge clk) disable iff (rst)
      $rose(hit_ovf[i]) |-> $past(hit_valid[i]));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
      rd_clr[i] |=> (!hit_valid[i] && !hit_ovf[i]));
  end
endmodule

bind tot_digitizer tot_digitizer_chk #(.NCH(NCH), .TSW(TSW)) u_chk (
  .clk(clk), .rst(rst), .rd_pop(rd_pop), .rd_clr(rd_clr),
  .hit_valid(hit_valid), .hit_tot(hit_tot), .hit_ts(hit_ts), .hit_ovf(hit_ovf)
);

// File: tb/tot_digitizer_bench.sv
module tot_digitizer_bench;
  localparam int NCH = 4;
  localparam int TSW = 5;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NCH-1:0]     disc = '0;
  logic [TSW-1:0]     tbase = '0;
  logic [NCH-1:0]     rd_pop = '0;
  logic [NCH-1:0]     rd_clr = '0;
  logic [NCH-1:0]     hit_valid;
  logic [NCH*4-1:0]   hit_tot;
  logic [NCH*TSW-1:0] hit_ts;
  logic [NCH-1:0]     hit_ovf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tot_digitizer #(.NCH(NCH), .TSW(TSW), .CW(16), .DEPTH(4)) u_tot_digitizer (
    .clk(clk), .rst(rst), .disc(disc), .tbase(tbase),
    .rd_pop(rd_pop), .rd_clr(rd_clr),
    .hit_valid(hit_valid), .hit_tot(hit_tot), .hit_ts(hit_ts), .hit_ovf(hit_ovf)
  );

  // stimulus table: pulse length in samples, time stamp, expected code
  localparam int NV = 9;
  localparam int unsigned V_LEN [NV] = '{1, 2, 3, 4, 7, 8, 15, 16, 100};
  localparam int unsigned V_TS  [NV] = '{2, 9, 16, 23, 30, 5, 12, 19, 31};
  localparam int unsigned V_EXP [NV] = '{0, 1, 1, 2, 2, 3, 3, 4, 6};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tot_of(input int ch);
    return int'(hit_tot[ch*4 +: 4]);
  endfunction

  function automatic int ts_of(input int ch);
    return int'(hit_ts[ch*TSW +: TSW]);
  endfunction

  task automatic pulse(input int ch, input int len, input int tb);
    @(negedge clk);
    tbase    = TSW'(tb);
    disc[ch] = 1'b1;
    repeat (len) @(negedge clk);
    disc[ch] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pop(input int ch);
    @(negedge clk);
    rd_pop[ch] = 1'b1;
    @(negedge clk);
    rd_pop[ch] = 1'b0;
  endtask

  task automatic clear(input int ch);
    @(negedge clk);
    rd_clr[ch] = 1'b1;
    @(negedge clk);
    rd_clr[ch] = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(hit_valid == '0, "R1 valid", int'(hit_valid), 0);
    chk(hit_ovf == '0, "R1 ovf", int'(hit_ovf), 0);

    // R2 R4: table of pulse lengths on channel 0
    for (int i = 0; i < NV; i++) begin
      pulse(0, int'(V_LEN[i]), int'(V_TS[i]));
      chk(hit_valid[0], "R2 valid", int'(hit_valid[0]), 1);
      chk(tot_of(0) == int'(V_EXP[i]), "R2 code", tot_of(0), int'(V_EXP[i]));
      chk(ts_of(0) == int'(V_TS[i]), "R4 stamp", ts_of(0), int'(V_TS[i]));
      pop(0);
      @(negedge clk);
      chk(!hit_valid[0], "R5 drained", int'(hit_valid[0]), 0);
    end

    // R5 R6: five hits into a four-entry store
    for (int k = 0; k < 5; k++) pulse(0, 2 << k, k + 1);
    chk(hit_ovf[0], "R6 ovf set", int'(hit_ovf[0]), 1);
    for (int k = 0; k < 4; k++) begin
      chk(hit_valid[0], "R5 held", int'(hit_valid[0]), 1);
      chk(tot_of(0) == k + 1, "R5 order code", tot_of(0), k + 1);
      chk(ts_of(0) == k + 1, "R5 order stamp", ts_of(0), k + 1);
      pop(0);
      @(negedge clk);
    end
    chk(!hit_valid[0], "R6 fifth dropped", int'(hit_valid[0]), 0);
    chk(hit_ovf[0], "R6 ovf sticky", int'(hit_ovf[0]), 1);

    // R7: clear drops records and overflow
    pulse(0, 5, 7);
    pulse(0, 6, 8);
    clear(0);
    chk(!hit_valid[0], "R7 empty", int'(hit_valid[0]), 0);
    chk(!hit_ovf[0], "R7 ovf cleared", int'(hit_ovf[0]), 0);

    // R9: pop channel 0 while channel 1 measures
    pulse(0, 3, 4);
    pulse(0, 9, 6);
    fork
      pulse(1, 20, 11);
      begin
        repeat (3) @(negedge clk);
        pop(0);
        pop(0);
      end
    join
    chk(!hit_valid[0], "R9 ch0 drained", int'(hit_valid[0]), 0);
    chk(hit_valid[1] && tot_of(1) == 4, "R9 ch1 code", tot_of(1), 4);
    chk(ts_of(1) == 11, "R9 ch1 stamp", ts_of(1), 11);
    pop(1);

    // R8: open pulse not reported across a pop
    @(negedge clk);
    tbase   = TSW'(3);
    disc[2] = 1'b1;
    repeat (10) @(negedge clk);
    chk(!hit_valid[2], "R8 open pulse", int'(hit_valid[2]), 0);
    rd_pop[2] = 1'b1;
    @(negedge clk);
    rd_pop[2] = 1'b0;
    @(negedge clk);
    chk(!hit_valid[2], "R8 after pop", int'(hit_valid[2]), 0);
    repeat (8) @(negedge clk);
    disc[2] = 1'b0;
    repeat (6) @(negedge clk);
    chk(hit_valid[2] && tot_of(2) == 4, "R8 closed code", tot_of(2), 4);
    chk(ts_of(2) == 3, "R8 closed stamp", ts_of(2), 3);

    // R10: pop on empty channel has no effect
    pop(3);
    pulse(3, 12, 20);
    chk(hit_valid[3] && tot_of(3) == 3, "R10 code", tot_of(3), 3);
    pop(3);
    @(negedge clk);
    chk(!hit_valid[3], "R10 single entry", int'(hit_valid[3]), 0);

    // R3: saturation on a very long pulse
    pulse(1, 70000, 14);
    chk(hit_valid[1] && tot_of(1) == 15, "R3 saturated", tot_of(1), 15);
    chk(ts_of(1) == 14, "R3 stamp", ts_of(1), 14);

    finish_run();
  end
endmodule